// File: doc/BRIEF.md
# Banked Scan Select and Data Multiplexer

This block sits between a narrow select/compress unit and a wide array of random-access scan cells. The array is split into equal banks, their number a power of two. The top bits of the segment address pick one bank. The remaining low bits go on to the narrow unit, which decodes them into a select word one bank wide. The block places that word onto the chosen bank's slice of the global select vector and holds every other bank's select lines at zero.

In the return direction, it collects the test outputs of the chosen bank and presents them as a narrow vector, with the cell order unchanged. The compressor behind it can then reduce that vector. The select/compress logic shrinks by a factor of 2^BANK_BITS. Observing every cell then takes at least one access per bank. With 256 cells and 3 bank bits, the narrow side is 32 bits wide and driven by 5 low address bits, and a full unload needs at least 8 operations.

The block is purely combinational: outputs follow inputs within the same cycle. Address generation and output compression belong to the neighbouring blocks.

Top module: `scan_bank_mux`

## Requirements
- R1: `low_addr` equals the low LOW_BITS bits of `seg_addr`, where BANK_W = CELLS / 2^BANK_BITS and LOW_BITS = log2(BANK_W). The default is 5 bits of an 8-bit address.
- R2: The bank index is `seg_addr[ADDR_W-1:LOW_BITS]`, and exactly one bank is active for every address value.
- R3: For active bank b, `cell_sel[b*BANK_W + i]` equals `bank_sel[i]` for every i in 0..BANK_W-1.
- R4: Every select line outside the active bank's slice is 0.
- R5: `bank_tq[i]` equals `cell_tq[b*BANK_W + i]` for the active bank b, in the same bit order.
- R6: Test outputs of cells outside the active bank have no effect on `bank_tq`.
- R7: Both directions are combinational. A change on `seg_addr`, `bank_sel` or `cell_tq` appears on the outputs with no clock edge in between.
- R8: Sweeping all 2^BANK_BITS bank indices with an all-ones `bank_sel` drives every one of the CELLS select lines exactly once in total. This takes 8 accesses for the default configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| seg_addr | input | ADDR_W (8) | Segment address; the top BANK_BITS bits choose the bank |
| low_addr | output | LOW_BITS (5) | Bank-local address passed on to the narrow select/compress unit |
| bank_sel | input | BANK_W (32) | Decoded select word from the narrow unit |
| cell_sel | output | CELLS (256) | Global select vector to the scan cells |
| cell_tq | input | CELLS (256) | Test outputs of all scan cells |
| bank_tq | output | BANK_W (32) | Test outputs of the active bank, in cell order |

## Verification
The hardest case to provoke is leakage: a bit of an idle bank reaching `bank_tq`, or a select bit reaching an idle bank. Random data rarely separates the right answer from a wrong bank in a single compare. The stimulus therefore keeps the active bank's outputs fixed and flips every test output bit outside it, then requires `bank_tq` to stay unchanged. Every bank index is visited with an all-ones, a walking-one and random select words. Every select bit is compared across the full 256-bit vector.

// File: rtl/scan_bank_pkg.sv
`timescale 1ns/1ps
package scan_bank_pkg;
    // first global cell index of a bank
    function automatic int bank_base(input int idx, input int width);
        return idx * width;
    endfunction
endpackage

// File: rtl/scan_bank_decode.sv
`timescale 1ns/1ps
module scan_bank_decode #(
    parameter int BANK_BITS = 3,
    localparam int NBANK    = 1 << BANK_BITS
) (
    input  logic [BANK_BITS-1:0] bank_idx,
    output logic [NBANK-1:0]     bank_en
);
    for (genvar b = 0; b < NBANK; b++) begin : g_dec
        assign bank_en[b] = (bank_idx == BANK_BITS'(b));
    end

    always_comb begin
        if (!$isunknown(bank_idx))
            AST_ONE_BANK_LIVE: assert ($onehot(bank_en)); // R2
    end
endmodule

// File: rtl/scan_sel_steer.sv
`timescale 1ns/1ps
module scan_sel_steer
    import scan_bank_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int BANK_W = 32,
    localparam int CELLS = NBANK * BANK_W
) (
    input  logic [NBANK-1:0]  bank_en,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [CELLS-1:0]  cell_sel
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int BASE = bank_base(b, BANK_W);
        assign cell_sel[BASE +: BANK_W] = bank_sel & {BANK_W{bank_en[b]}};

        always_comb begin
            if (!$isunknown(bank_en) && !bank_en[b])
                AST_IDLE_BANK_QUIET: assert (cell_sel[BASE +: BANK_W] == '0); // R4
        end
    end

    always_comb begin
        if (!$isunknown({bank_en, bank_sel}) && $onehot(bank_en))
            AST_SEL_COUNT_KEPT: assert ($countones(cell_sel) == $countones(bank_sel)); // R3
    end
endmodule

// File: rtl/scan_tq_gather.sv
`timescale 1ns/1ps
module scan_tq_gather #(
    parameter int NBANK  = 8,
    parameter int BANK_W = 32,
    localparam int CELLS = NBANK * BANK_W
) (
    input  logic [NBANK-1:0]  bank_en,
    input  logic [CELLS-1:0]  cell_tq,
    output logic [BANK_W-1:0] bank_tq
);
    always_comb begin
        bank_tq = '0;
        for (int b = 0; b < NBANK; b++)
            bank_tq |= cell_tq[b*BANK_W +: BANK_W] & {BANK_W{bank_en[b]}};
    end

    always_comb begin
        if (!$isunknown(cell_tq) && cell_tq == '0)
            AST_QUIET_ARRAY_QUIET_OUT: assert (bank_tq == '0); // R6
    end
endmodule

// File: rtl/scan_bank_mux.sv
`timescale 1ns/1ps
module scan_bank_mux #(
    parameter int CELLS     = 256,
    parameter int BANK_BITS = 3,
    localparam int NBANK    = 1 << BANK_BITS,
    localparam int BANK_W   = CELLS / NBANK,
    localparam int LOW_BITS = $clog2(BANK_W),
    localparam int ADDR_W   = LOW_BITS + BANK_BITS
) (
    input  logic [ADDR_W-1:0]   seg_addr,
    output logic [LOW_BITS-1:0] low_addr,
    input  logic [BANK_W-1:0]   bank_sel,
    output logic [CELLS-1:0]    cell_sel,
    input  logic [CELLS-1:0]    cell_tq,
    output logic [BANK_W-1:0]   bank_tq
);
    logic [BANK_BITS-1:0] bank_idx;
    logic [NBANK-1:0]     bank_en;

    assign bank_idx = seg_addr[ADDR_W-1:LOW_BITS];
    assign low_addr = seg_addr[LOW_BITS-1:0];

    scan_bank_decode #(.BANK_BITS(BANK_BITS)) u_decode (
        .bank_idx (bank_idx),
        .bank_en  (bank_en)
    );

    scan_sel_steer #(.NBANK(NBANK), .BANK_W(BANK_W)) u_steer (
        .bank_en  (bank_en),
        .bank_sel (bank_sel),
        .cell_sel (cell_sel)
    );

    scan_tq_gather #(.NBANK(NBANK), .BANK_W(BANK_W)) u_gather (
        .bank_en  (bank_en),
        .cell_tq  (cell_tq),
        .bank_tq  (bank_tq)
    );

    always_comb begin
        if (!$isunknown({seg_addr, bank_sel, cell_tq})) begin
            AST_SEL_LANDS_IN_BANK: assert (cell_sel[int'(bank_idx)*BANK_W +: BANK_W] == bank_sel); // R3
            AST_TQ_FROM_BANK: assert (bank_tq == cell_tq[int'(bank_idx)*BANK_W +: BANK_W]); // R5
        end
    end
endmodule

// File: tb/scan_bank_mux_test.sv
`timescale 1ns/1ps
module scan_bank_mux_test;
    localparam int CELLS = 256;
    localparam int BB    = 3;
    localparam int NB    = 1 << BB;
    localparam int BW    = CELLS / NB;
    localparam int LB    = $clog2(BW);
    localparam int AW    = LB + BB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0]    seg_addr;
    logic [LB-1:0]    low_addr;
    logic [BW-1:0]    bank_sel;
    logic [CELLS-1:0] cell_sel;
    logic [CELLS-1:0] cell_tq;
    logic [BW-1:0]    bank_tq;

    scan_bank_mux #(.CELLS(CELLS), .BANK_BITS(BB)) uut (
        .seg_addr (seg_addr),
        .low_addr (low_addr),
        .bank_sel (bank_sel),
        .cell_sel (cell_sel),
        .cell_tq  (cell_tq),
        .bank_tq  (bank_tq)
    );

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    task automatic check(input string req, input logic [CELLS-1:0] act, input logic [CELLS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    function automatic logic [CELLS-1:0] place(input logic [BW-1:0] w, input int b);
        logic [CELLS-1:0] t;
        t = '0;
        t[BW-1:0] = w;
        return t << (b * BW);
    endfunction

    initial begin
        logic [CELLS-1:0] cover_sel;
        logic [CELLS-1:0] tq;
        logic [CELLS-1:0] mask;
        logic [BW-1:0]    bsel;
        logic [LB-1:0]    lo;
        seg_addr = '0;
        bank_sel = '0;
        cell_tq  = '0;
        cover_sel = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // idle state: everything zero
        check("R4 idle select", cell_sel, '0);
        check("R5 idle data", CELLS'(bank_tq), '0);
        check("R1 idle low addr", CELLS'(low_addr), '0);

        for (int b = 0; b < NB; b++) begin
            for (int p = 0; p < 6; p++) begin
                lo = LB'($urandom);
                if (p == 0)      bsel = '1;
                else if (p == 1) bsel = BW'(1) << lo;
                else             bsel = BW'($urandom);
                for (int k = 0; k < CELLS / 32; k++) tq[k*32 +: 32] = $urandom;
                mask = place('1, b);
                @(posedge clk);
                seg_addr = {BB'(b), lo};
                bank_sel = bsel;
                cell_tq  = tq;
                @(negedge clk);
                check("R1 low addr", CELLS'(low_addr), CELLS'(lo));
                check("R3 select placement", cell_sel, place(bsel, b));
                check("R4 idle banks zero", cell_sel & ~mask, '0);
                check("R5 bank data", CELLS'(bank_tq), CELLS'(BW'(tq >> (b * BW))));
                if (p == 0) cover_sel = cover_sel | cell_sel;
                // R6: flip every test output outside the bank
                @(posedge clk);
                cell_tq = tq ^ ~mask;
                @(negedge clk);
                check("R6 outside bits ignored", CELLS'(bank_tq), CELLS'(BW'(tq >> (b * BW))));
                check("R2 single bank driven", CELLS'($countones(cell_sel)), CELLS'($countones(bsel)));
            end
        end
        check("R8 full coverage over banks", cover_sel, '1);

        // R7: change inputs between clock edges, look before the next edge
        @(negedge clk);
        seg_addr = {BB'(NB - 1), LB'(3)};
        bank_sel = BW'(32'hA5A5_0F0F);
        cell_tq  = place(BW'(32'h1234_5678), NB - 1);
        #1;
        check("R7 select same cycle", cell_sel, place(BW'(32'hA5A5_0F0F), NB - 1));
        check("R7 data same cycle", CELLS'(bank_tq), CELLS'(BW'(32'h1234_5678)));
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        report();
    end
endmodule